// File: doc/BRIEF.md
# Mode-Configurable Cascadable Display Shift Register

This block is the serial input stage of a multiplexed segment display driver. A host sends display bits on a data line, a serial clock line and an enable line. The block samples these three lines in a fast system clock domain. While the enable is high, each rising serial clock edge shifts one bit into a chain of up to three 32-bit sections. The whole image is presented as a 96-bit vector to a downstream display latch. The block also drives a serial cascade output, with its own output-enable, so that several drivers can be daisy-chained on one bus.

A two-bit drive-mode input sets how many sections are linked: one (static, 32 bits), two (duplex, 64 bits) or three (triplex, 96 bits). The cascade output always comes from the last bit of the last linked section. It is updated on the falling serial clock edge, so it trails the data input by half a serial clock period. It is released when the enable drops and keeps its last value. A single-cycle completion pulse on the falling enable tells the latch stage that a new frame of data is ready.

Top module: `disp_shift_chain`

## Requirements
- R1: After reset, `image` is all zeros, `casc_out` is 0, `casc_oe` is 0 and `frame_done` is 0.
- R2: A rising `ser_clk` edge while `ser_en` is high shifts `ser_data` into position 1 of section A (`image[0]`). Every bit moves one position up, so in each section the first bit shifted in ends at position 32 (`image[32*k+31]` for section k).
- R3: `mode` selects the chain length. `2'b01` links section A only (32 bits), `2'b10` links A then B (64 bits), and `2'b11` links A, B and C (96 bits). Position 32 of each linked section feeds position 1 of the next linked section. `2'b00` behaves exactly like `2'b01`.
- R4: Sections outside the selected chain read as zero in `image`: bits 95:32 in `2'b01`/`2'b00`, and bits 95:64 in `2'b10`.
- R5: The cascade data taken is the last active bit: `image[31]`, `image[63]` or `image[95]` for 1, 2 or 3 linked sections.
- R6: `casc_out` loads the tap only on a falling `ser_clk` edge while `ser_en` is high. After a rising edge, and until the next falling edge, it still shows the value from before that shift.
- R7: `casc_oe` is high while the synchronized `ser_en` is high and low otherwise. `casc_out` keeps its last value after `ser_en` drops.
- R8: `frame_done` is a one-system-cycle pulse raised once for each falling edge of the synchronized `ser_en`. It appears in the same cycle that `casc_oe` falls.
- R9: `ser_clk` edges while `ser_en` is low change neither `image` nor `casc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `ser_clk` |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous to `clk` |
| ser_data | input | 1 | Serial display data |
| ser_en | input | 1 | Serial enable, shifting allowed while high |
| mode | input | 2 | Drive mode: 00 test (as static), 01 static, 10 duplex, 11 triplex |
| image | output | 96 | Parallel image; section A in 31:0, B in 63:32, C in 95:64 |
| casc_out | output | 1 | Cascade data toward the next driver |
| casc_oe | output | 1 | Output-enable for `casc_out` (high = driven) |
| frame_done | output | 1 | One-cycle pulse when the enable falls |

## Verification
The assertions take for granted that `ser_clk` stays at each level for at least three system clocks. This lets every serial edge pass the synchronizers and become its own one-cycle strobe. They also assume that `ser_data` is stable around each rising serial edge and that `mode` changes only while no shift is pending. The stimulus holds each serial clock phase for five system cycles and changes data only while `ser_clk` is low. It changes `mode` only while `ser_en` is low. Frames use random bits with random lengths around the chain length, mixed with directed cases for ordering, ignored clocks and the test-mode encoding.

// File: rtl/disp_shift_pkg.sv
// Shared constants and helpers for the display shift chain.
// Assumes a fixed count of equal-width sections linked in order A, B, C.
package disp_shift_pkg;
    localparam int SECT_W  = 32;
    localparam int N_SECT  = 3;
    localparam int IMG_W   = SECT_W * N_SECT;

    typedef enum logic [1:0] {
        MODE_TEST  = 2'b00,
        MODE_ONE   = 2'b01,
        MODE_TWO   = 2'b10,
        MODE_THREE = 2'b11
    } drive_mode_e;

    // Number of linked sections for a drive mode (test mode acts as static).
    function automatic int linked_sections(input logic [1:0] m);
        case (m)
            MODE_TWO:   return 2;
            MODE_THREE: return 3;
            default:    return 1;
        endcase
    endfunction
endpackage

// File: rtl/ser_sync_edge.sv
// Brings the serial clock, data and enable into the system clock domain
// through STAGES-deep synchronizers, and turns serial clock and enable
// transitions into single-cycle strobes.
// Assumes each serial level is held for more than STAGES+1 system cycles.
module ser_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_data,
    input  logic ser_en,
    output logic rise_stb,
    output logic fall_stb,
    output logic data_s,
    output logic en_s,
    output logic en_fall_stb
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] sync_q [STAGES];
    logic            clk_d;
    logic            en_d;

    // Synchronizer chain for all three serial lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) sync_q[i] <= '0;
        end else begin
            sync_q[0] <= {ser_en, ser_data, ser_clk};
            for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    // Delayed copies used to find edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_d <= 1'b0;
            en_d  <= 1'b0;
        end else begin
            clk_d <= sync_q[STAGES-1][0];
            en_d  <= sync_q[STAGES-1][2];
        end
    end

    // Strobe decode from the synchronized values.
    always_comb begin
        data_s      = sync_q[STAGES-1][1];
        en_s        = sync_q[STAGES-1][2];
        rise_stb    =  sync_q[STAGES-1][0] & ~clk_d;
        fall_stb    = ~sync_q[STAGES-1][0] &  clk_d;
        en_fall_stb = ~en_s & en_d;
    end
endmodule

// File: rtl/shift_section.sv
// One fixed-width shift section. Bit 0 is position 1 and takes new data;
// bit W-1 is position W and feeds the next section.
// Assumes the caller clears it whenever it is not part of the chain.
module shift_section #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    // Shift when asked; hold zero while outside the chain.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) q <= '0;
        else if (shift)        q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/casc_tap.sv
// Picks the last active bit for the mode and retimes it to the falling
// serial clock strobe; holds the value otherwise.
// Assumes the image is laid out as N consecutive W-bit sections.
module casc_tap
    import disp_shift_pkg::*;
#(
    parameter int W = SECT_W,
    parameter int N = N_SECT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic [W*N-1:0] image,
    input  logic         fall_stb,
    input  logic         en_s,
    output logic         casc_out
);
    logic tap;

    // Select position W of the last linked section.
    always_comb begin
        tap = image[W-1];
        for (int k = 1; k < N; k++)
            if (linked_sections(mode) == k + 1) tap = image[W*(k+1)-1];
    end

    // Load the cascade bit on a falling serial edge during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                casc_out <= 1'b0;
        else if (fall_stb && en_s) casc_out <= tap;
    end
endmodule

// File: rtl/disp_shift_chain.sv
// Top of the serial display input path: synchronizes the serial bus,
// links one to three shift sections by drive mode, and drives the cascade
// output with its enable and a frame completion pulse.
// Assumes mode is held steady during a transfer.
module disp_shift_chain
    import disp_shift_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_en,
    input  logic [1:0]       mode,
    output logic [IMG_W-1:0] image,
    output logic             casc_out,
    output logic             casc_oe,
    output logic             frame_done
);
    logic rise_stb, fall_stb, data_s, en_s, en_fall_stb;
    logic shift_stb;
    logic [N_SECT-1:0][SECT_W-1:0] sect_q;
    logic [N_SECT-1:0]             sect_din;

    ser_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
        .rise_stb(rise_stb), .fall_stb(fall_stb),
        .data_s(data_s), .en_s(en_s), .en_fall_stb(en_fall_stb)
    );

    // Shift only on a rising serial edge during a transfer.
    always_comb shift_stb = rise_stb & en_s;

    genvar k;
    generate
        for (k = 0; k < N_SECT; k++) begin : g_sect
            if (k == 0) begin : g_head
                always_comb sect_din[k] = data_s;
            end else begin : g_link
                always_comb sect_din[k] = sect_q[k-1][SECT_W-1];
            end
            shift_section #(.W(SECT_W)) sect_i (
                .clk(clk), .rst_n(rst_n),
                .active(linked_sections(mode) > k),
                .shift(shift_stb), .din(sect_din[k]), .q(sect_q[k])
            );
        end
    endgenerate

    // Flatten sections into the parallel image, A in the low bits.
    always_comb image = sect_q;

    casc_tap #(.W(SECT_W), .N(N_SECT)) tap_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .image(image),
        .fall_stb(fall_stb), .en_s(en_s), .casc_out(casc_out)
    );

    // Output-enable and completion pulse from the synchronized enable.
    always_comb begin
        casc_oe    = en_s;
        frame_done = en_fall_stb;
    end
endmodule

// File: rtl/disp_shift_chain_chk.sv
// Property checker for disp_shift_chain, attached by bind below.
// Assumes mode changes only between transfers.
module disp_shift_chain_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  mode,
    input logic [95:0] image,
    input logic        casc_out,
    input logic        casc_oe,
    input logic        frame_done,
    input logic        fall_stb,
    input logic        shift_stb
);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R8
    done_on_oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(casc_oe) |-> frame_done);

    // R6
    casc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_stb |=> $stable(casc_out));

    // R4
    static_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |=> (image[95:32] == '0));

    // R4
    duplex_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (image[95:64] == '0));

    // R9
    image_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_stb && $stable(mode)) |=> $stable(image));
endmodule

bind disp_shift_chain disp_shift_chain_chk chk_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .image(image),
    .casc_out(casc_out), .casc_oe(casc_oe), .frame_done(frame_done),
    .fall_stb(fall_stb), .shift_stb(shift_stb)
);

// File: tb/disp_shift_chain_tb_top.sv
module disp_shift_chain_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
    logic [1:0]  mode = 2'b01;
    logic [95:0] image;
    logic        casc_out, casc_oe, frame_done;

    int n_cmp = 0, n_bad = 0, done_cnt = 0;
    bit finished = 0;
    logic [95:0] m_img;
    logic        m_casc;

    always #5 clk = ~clk;

    disp_shift_chain dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(ser_en), .mode(mode), .image(image), .casc_out(casc_out),
        .casc_oe(casc_oe), .frame_done(frame_done)
    );

    always @(negedge clk) if (rst_n && frame_done) done_cnt++;

    function automatic int n_linked(input logic [1:0] m);
        return (m == 2'b11) ? 3 : (m == 2'b10) ? 2 : 1;
    endfunction

    function automatic logic [95:0] mask_img(input logic [95:0] v, input logic [1:0] m);
        logic [95:0] r = v;
        if (n_linked(m) < 3) r[95:64] = '0;
        if (n_linked(m) < 2) r[63:32] = '0;
        return r;
    endfunction

    function automatic logic [95:0] shift_model(input logic [95:0] v, input logic [1:0] m, input logic b);
        return mask_img({v[94:0], b}, m);
    endfunction

    function automatic logic tap_model(input logic [95:0] v, input logic [1:0] m);
        return v[32*n_linked(m)-1];
    endfunction

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode = m;
        m_img = mask_img(m_img, m);
        wait_cyc(3);
    endtask

    // One serial bit; optionally check the half-cycle lag of the cascade.
    task automatic send_bit(input logic b, input bit lag_chk);
        ser_data = b;
        wait_cyc(5);
        ser_clk = 1'b1;
        wait_cyc(5);
        if (ser_en) m_img = shift_model(m_img, mode, b);
        if (lag_chk) check("R6 lag", {95'd0, casc_out}, {95'd0, m_casc});
        ser_clk = 1'b0;
        wait_cyc(5);
        if (ser_en) m_casc = tap_model(m_img, mode);
    endtask

    task automatic send_frame(input int nbits, input string tag);
        int d0 = done_cnt;
        ser_en = 1'b1;
        wait_cyc(5);
        check({tag, " R7 oe high"}, {95'd0, casc_oe}, 96'd1);
        for (int i = 0; i < nbits; i++) send_bit($urandom_range(0, 1), (i % 7) == 3);
        ser_en = 1'b0;
        wait_cyc(5);
        check({tag, " R3 image"}, image, m_img);
        check({tag, " R5 casc"}, {95'd0, casc_out}, {95'd0, m_casc});
        check({tag, " R7 oe low / hold"}, {94'd0, casc_oe, casc_out}, {94'd0, 1'b0, m_casc});
        check({tag, " R8 one pulse"}, done_cnt - d0, 1);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        m_img = '0;
        m_casc = 1'b0;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1 reset state
        check("R1 image", image, '0);
        check("R1 casc_out", {95'd0, casc_out}, '0);
        check("R1 casc_oe", {95'd0, casc_oe}, '0);
        check("R1 frame_done", {95'd0, frame_done}, '0);

        // R2 ordering: a lone 1 followed by 31 zeros lands at position 32
        set_mode(2'b01);
        ser_en = 1'b1;
        wait_cyc(5);
        send_bit(1'b1, 0);
        for (int i = 0; i < 31; i++) send_bit(1'b0, 0);
        check("R2 first bit at position 32", image, 96'h8000_0000);
        check("R5 static tap", {95'd0, casc_out}, 96'd1);
        ser_en = 1'b0;
        wait_cyc(5);

        // R9 serial clocks while disabled are ignored
        for (int i = 0; i < 5; i++) send_bit(1'b1, 0);
        check("R9 image unchanged", image, m_img);
        check("R9 casc unchanged", {95'd0, casc_out}, {95'd0, m_casc});

        // R3/R4/R5 random frames in every mode, including test mode
        for (int r = 0; r < 3; r++) begin
            set_mode(2'b01); send_frame(32 + $urandom_range(0, 8), "static");
            set_mode(2'b10); send_frame(64 + $urandom_range(0, 8), "duplex");
            set_mode(2'b11); send_frame(96 + $urandom_range(0, 8), "triplex");
            set_mode(2'b00); send_frame(32 + $urandom_range(0, 8), "test-as-static");
            check("R4 unused zero", image[95:32], '0);
        end

        // R4 shrink from triplex to duplex clears section C
        set_mode(2'b11); send_frame(96, "pre-shrink");
        set_mode(2'b10);
        check("R4 section C cleared", image, m_img);

        // R2 partial frame, one bit
        set_mode(2'b11); send_frame(1, "single-bit");

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule